// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a synchronous static RAM with a read pipeline. The data word is 64 bits wide and is split into eight byte lanes. The depth is set by a parameter and is kept small. Every control, address and write-data input is sampled on the rising clock edge. Two start strobes open an access. One is a processor-side strobe and the other is a controller-side strobe, and their precedence rules differ. After an access has started, an advance input either steps through a short wrapping burst or holds the current address to add wait states. The burst can step in linear order or in exclusive-or order.

Five chip-enable terms are looked at only on edges that carry a start strobe. A read fills an internal stage on the access edge, the output register on the next edge, and the bus from then on. The bus is gated at once by an active-low output enable. A sleep input parks the memory and keeps its contents. A short recovery window follows wake-up. A strobe that arrives inside that window is dropped and is recorded in a sticky flag.

Top module: `pipe_burst_ram`

## Requirements
- R1: After reset, `rdata_oe` is 0, `rdata` is all zeros and `proto_err` is 0.
- R2: The chip counts as selected only when `ce_n`=0, both bits of `en_hi` are 1 and both bits of `en_lo_n` are 0. A start strobe on an edge where the chip is not selected ends any burst, performs no write, and leaves the bus undriven for that access.
- R3: While `ce_n`=1, a low `proc_stb_n` has no effect. That edge is handled as if the processor strobe were high, so an open burst goes on continuing or suspending.
- R4: When `proc_stb_n`=0 and the chip is selected, the access is a read of `addr`, whatever the write inputs are set to.
- R5: When `ctrl_stb_n`=0 and the processor strobe does not take the edge, a selected edge loads `addr`. It writes if the write condition holds and reads otherwise.
- R6: The write condition holds when `glob_we_n`=0, which writes all eight lanes. It also holds when `byte_we_n`=0 and at least one `lane_we_n[n]` is 0, which writes only those lanes. Lane n is `wdata[8n+7:8n]`. With `byte_we_n`=1, low lane bits write nothing.
- R7: With both strobes high inside an open burst, `adv_n`=0 moves to the next beat. The beat's cycle type comes from the write condition. The low two address bits are (start+k) mod 4 when `burst_lin`=1 and start XOR k when `burst_lin`=0. The upper bits stay fixed.
- R8: With both strobes high inside an open burst, `adv_n`=1 keeps the current address and performs a read or a write there.
- R9: Read data of an access at edge E is on `rdata` with `rdata_oe`=1 after edge E+1. After a write access the bus stays undriven.
- R10: `oe_n`=1 forces `rdata_oe` to 0 and `rdata` to zero without waiting for a clock edge.
- R11: An edge with `sleep`=1 ignores strobes, advance and write inputs, closes the burst, and turns the bus off. Memory contents are kept.
- R12: For the 2 edges after `sleep` returns to 0, all inputs are ignored. A strobe seen in that window sets `proto_err`, which stays set until reset.
- R13: With no burst open, edges with both strobes high do nothing and the bus stays undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Word address, loaded when a start strobe is accepted |
| proc_stb_n | input | 1 | Processor-side start strobe, active low, always a read |
| ctrl_stb_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high holds the address |
| ce_n | input | 1 | Main chip enable, active low; also masks the processor strobe |
| en_hi | input | 2 | Secondary enables, both must be 1 |
| en_lo_n | input | 2 | Secondary enables, both must be 0 |
| glob_we_n | input | 1 | Global write of all lanes, active low |
| byte_we_n | input | 1 | Master enable for the per-lane writes, active low |
| lane_we_n | input | DW/8 | Per-lane write enables, active low |
| wdata | input | DW | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| burst_lin | input | 1 | 1 selects linear burst order, 0 selects XOR order |
| rdata | output | DW | Read data, zero when not driven |
| rdata_oe | output | 1 | Bus drive enable |
| proto_err | output | 1 | Sticky flag for a strobe inside the wake window |

## Verification
The bench writes every word, then reads each one back with the processor strobe while all write inputs are held active. A design that let those write inputs win would corrupt the array and return wrong words. Bursts run in both orders from start addresses that wrap inside the group of four. One burst is opened by a processor read and is followed by a suspended partial write on the same address, which catches an off-by-one in the beat counter or a wrongly swapped order. The bench also sends a processor strobe while the main enable is high; a design that did not mask it would restart the burst instead of continuing it. Sleep is entered while a read is still in flight, and a strobe is placed inside the wake window. A design that leaked the pending read onto the bus, or that accepted the late write, would show stale data or a changed word.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;
endpackage

// File: rtl/pbr_sleep.sv
module pbr_sleep #(
   parameter int WAKE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   input  logic strobe_seen,
   output logic hold,
   output logic parked,
   output logic proto_err
);
   localparam int RW = $clog2(WAKE_CYC + 1);

   logic [RW-1:0] rec_q;

   assign hold = sleep | (rec_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_q     <= '0;
         parked    <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         parked <= sleep;
         if (sleep) begin
            rec_q <= RW'(WAKE_CYC);
         end else if (rec_q != '0) begin
            rec_q <= rec_q - 1'b1;
            if (strobe_seen) proto_err <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pbr_decode.sv
module pbr_decode
   import pbr_pkg::*;
#(
   parameter int AW        = 6,
   parameter int BURST_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic [AW-1:0] addr,
   input  logic          proc_stb_n,
   input  logic          ctrl_stb_n,
   input  logic          adv_n,
   input  logic          ce_n,
   input  logic [1:0]    en_hi,
   input  logic [1:0]    en_lo_n,
   input  logic          wr_req,
   input  logic          burst_lin,
   output acc_e          acc,
   output logic [AW-1:0] acc_addr
);
   localparam int CW = $clog2(BURST_LEN);

   logic [AW-1:0] base_q, base_n;
   logic [CW-1:0] cnt_q, cnt_n, cnt_step;
   logic [CW-1:0] lo_lin, lo_xor;
   logic          active_q, active_n;
   logic          sel, p_go, c_go;

   assign sel      = !ce_n && (&en_hi) && !(|en_lo_n);
   assign p_go     = !proc_stb_n && !ce_n;
   assign c_go     = !ctrl_stb_n && !p_go;
   assign cnt_step = adv_n ? cnt_q : cnt_q + 1'b1;
   assign lo_lin   = base_q[CW-1:0] + cnt_step;
   assign lo_xor   = base_q[CW-1:0] ^ cnt_step;

   always_comb begin
      acc      = ACC_NONE;
      acc_addr = {base_q[AW-1:CW], (burst_lin ? lo_lin : lo_xor)};
      base_n   = base_q;
      cnt_n    = cnt_q;
      active_n = active_q;
      if (hold) begin
         active_n = 1'b0;
      end else if (p_go || c_go) begin
         if (sel) begin
            active_n = 1'b1;
            base_n   = addr;
            cnt_n    = '0;
            acc_addr = addr;
            acc      = (!p_go && wr_req) ? ACC_WRITE : ACC_READ;
         end else begin
            active_n = 1'b0;
         end
      end else if (active_q) begin
         cnt_n = cnt_step;
         acc   = wr_req ? ACC_WRITE : ACC_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else begin
         base_q   <= base_n;
         cnt_q    <= cnt_n;
         active_q <= active_n;
      end
   end
endmodule

// File: rtl/pbr_lanes.sv
module pbr_lanes #(
   parameter int AW    = 6,
   parameter int LANES = 8
) (
   input  logic               clk,
   input  logic [LANES-1:0]   we,
   input  logic [AW-1:0]      waddr,
   input  logic [8*LANES-1:0] wdata,
   input  logic [AW-1:0]      raddr,
   output logic [8*LANES-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (we[l]) cells[waddr] <= wdata[l*8 +: 8];
      end
      assign rdata[l*8 +: 8] = cells[raddr];
   end
endmodule

// File: rtl/pipe_burst_ram.sv
module pipe_burst_ram
   import pbr_pkg::*;
#(
   parameter int AW        = 6,
   parameter int DW        = 64,
   parameter int BURST_LEN = 4,
   parameter int WAKE_CYC  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   addr,
   input  logic            proc_stb_n,
   input  logic            ctrl_stb_n,
   input  logic            adv_n,
   input  logic            ce_n,
   input  logic [1:0]      en_hi,
   input  logic [1:0]      en_lo_n,
   input  logic            glob_we_n,
   input  logic            byte_we_n,
   input  logic [DW/8-1:0] lane_we_n,
   input  logic [DW-1:0]   wdata,
   input  logic            oe_n,
   input  logic            sleep,
   input  logic            burst_lin,
   output logic [DW-1:0]   rdata,
   output logic            rdata_oe,
   output logic            proto_err
);
   localparam int LANES = DW / 8;

   if (DW % 8 != 0) begin : g_bad_dw
      $error("DW must be a whole number of bytes");
   end
   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_bl
      $error("BURST_LEN must be a power of two of at least 2");
   end
   if ((1 << AW) < BURST_LEN) begin : g_bad_aw
      $error("AW too small for one burst");
   end
   if (WAKE_CYC < 1) begin : g_bad_wk
      $error("WAKE_CYC must be at least 1");
   end

   logic             wr_req, hold, parked;
   logic [LANES-1:0] lane_mask, we;
   acc_e             acc;
   logic [AW-1:0]    acc_addr, rd_addr_q;
   logic [DW-1:0]    mem_rd, q_q;
   logic             rd_pend_q, valid_q, drive;

   assign wr_req    = !glob_we_n || (!byte_we_n && !(&lane_we_n));
   assign lane_mask = !glob_we_n ? '1 : (!byte_we_n ? ~lane_we_n : '0);
   assign we        = (acc == ACC_WRITE) ? lane_mask : '0;

   pbr_sleep #(.WAKE_CYC(WAKE_CYC)) u_sleep (
      .clk(clk), .rst_n(rst_n), .sleep(sleep),
      .strobe_seen(!proc_stb_n || !ctrl_stb_n),
      .hold(hold), .parked(parked), .proto_err(proto_err)
   );

   pbr_decode #(.AW(AW), .BURST_LEN(BURST_LEN)) u_dec (
      .clk(clk), .rst_n(rst_n), .hold(hold), .addr(addr),
      .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
      .ce_n(ce_n), .en_hi(en_hi), .en_lo_n(en_lo_n), .wr_req(wr_req),
      .burst_lin(burst_lin), .acc(acc), .acc_addr(acc_addr)
   );

   pbr_lanes #(.AW(AW), .LANES(LANES)) u_mem (
      .clk(clk), .we(we), .waddr(acc_addr), .wdata(wdata),
      .raddr(rd_addr_q), .rdata(mem_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend_q <= 1'b0;
         rd_addr_q <= '0;
         valid_q   <= 1'b0;
         q_q       <= '0;
      end else begin
         rd_pend_q <= (acc == ACC_READ);
         rd_addr_q <= acc_addr;
         valid_q   <= rd_pend_q;
         if (rd_pend_q) q_q <= mem_rd;
      end
   end

   assign drive    = valid_q && !oe_n && !parked;
   assign rdata_oe = drive;
   assign rdata    = drive ? q_q : '0;
endmodule

// File: rtl/pipe_burst_ram_chk.sv
module pipe_burst_ram_chk #(
   parameter int DW = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            proc_stb_n,
   input logic            ctrl_stb_n,
   input logic            ce_n,
   input logic [1:0]      en_hi,
   input logic [1:0]      en_lo_n,
   input logic            glob_we_n,
   input logic            byte_we_n,
   input logic [DW/8-1:0] lane_we_n,
   input logic            oe_n,
   input logic            sleep,
   input logic            rdata_oe,
   input logic            proto_err
);
   logic sel_c, ctrl_takes, wcond_c;
   assign sel_c      = !ce_n && (&en_hi) && !(|en_lo_n);
   assign ctrl_takes = !ctrl_stb_n && !(!proc_stb_n && !ce_n);
   assign wcond_c    = !glob_we_n || (!byte_we_n && (lane_we_n != '1));

   AST_OE_GATES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rdata_oe); // R10
   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !rdata_oe); // R11
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err); // R12
   AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_takes && sel_c && wcond_c) |-> ##2 !rdata_oe); // R9
   AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_takes && !sel_c) |-> ##2 !rdata_oe); // R2
endmodule

bind pipe_burst_ram pipe_burst_ram_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
   .ce_n(ce_n), .en_hi(en_hi), .en_lo_n(en_lo_n), .glob_we_n(glob_we_n),
   .byte_we_n(byte_we_n), .lane_we_n(lane_we_n), .oe_n(oe_n), .sleep(sleep),
   .rdata_oe(rdata_oe), .proto_err(proto_err)
);

// File: tb/pipe_burst_ram_tb_top.sv
`timescale 1ns/1ps
module pipe_burst_ram_tb_top;
   localparam int AW = 6, DW = 64, DEPTH = 64;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, proc_stb_n, ctrl_stb_n, adv_n, ce_n, glob_we_n, byte_we_n;
   logic oe_n, sleep, burst_lin, rdata_oe, proto_err;
   logic [AW-1:0] addr;
   logic [1:0]    en_hi, en_lo_n;
   logic [7:0]    lane_we_n;
   logic [DW-1:0] wdata, rdata;

   int n_chk = 0, n_bad = 0;
   logic [63:0] ref_m [DEPTH];
   bit          pend_v = 0;
   logic [63:0] pend_d = '0;
   string       pend_tag = "R9";

   pipe_burst_ram dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n),
      .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .ce_n(ce_n), .en_hi(en_hi),
      .en_lo_n(en_lo_n), .glob_we_n(glob_we_n), .byte_we_n(byte_we_n),
      .lane_we_n(lane_we_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
      .burst_lin(burst_lin), .rdata(rdata), .rdata_oe(rdata_oe), .proto_err(proto_err)
   );

   function automatic logic [63:0] pat(int a, int s);
      return (64'h9e3779b97f4a7c15 * 64'(a + 1)) ^ {8{8'(s)}};
   endfunction

   function automatic int lin(int b, int k);
      return (b & ~3) | ((b + k) & 3);
   endfunction

   function automatic int xo(int b, int k);
      return (b & ~3) | ((b ^ k) & 3);
   endfunction

   task automatic merge(int a, logic [63:0] d, logic [7:0] mask);
      for (int l = 0; l < 8; l++) if (mask[l]) ref_m[a][l*8 +: 8] = d[l*8 +: 8];
   endtask

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic idle_in();
      proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1; ce_n = 0; en_hi = 2'b11; en_lo_n = 2'b00;
      glob_we_n = 1; byte_we_n = 1; lane_we_n = 8'hFF; oe_n = 0; sleep = 0;
   endtask

   // one clock: checks the access issued in the previous call, records this one
   task automatic step(bit ev, logic [63:0] ed, string tag);
      bit xd;
      @(posedge clk);
      @(negedge clk);
      xd = pend_v && !oe_n;
      check(rdata_oe === xd, pend_tag, "drive", 64'(rdata_oe), 64'(xd));
      check(rdata === (xd ? pend_d : 64'h0), pend_tag, "data", rdata, xd ? pend_d : 64'h0);
      pend_v = ev; pend_d = ed; pend_tag = tag;
   endtask

   task automatic rd_p(int a, bit junk);
      idle_in(); proc_stb_n = 0; addr = AW'(a);
      if (junk) begin glob_we_n = 0; byte_we_n = 0; lane_we_n = 8'h00; wdata = ~ref_m[a]; end
      step(1, ref_m[a], "R4");
   endtask

   task automatic wr_c(int a, logic [63:0] d, bit use_glob, logic [7:0] lanes);
      idle_in(); ctrl_stb_n = 0; addr = AW'(a); wdata = d;
      if (use_glob) glob_we_n = 0; else begin byte_we_n = 0; lane_we_n = lanes; end
      merge(a, d, use_glob ? 8'hFF : ~lanes);
      step(0, '0, "R5");
   endtask

   task automatic desel(string tag);
      idle_in(); ctrl_stb_n = 0; ce_n = 1;
      step(0, '0, tag);
   endtask

   task automatic beat_rd(int a, bit adv, string tag);
      idle_in(); adv_n = !adv;
      step(1, ref_m[a], tag);
   endtask

   task automatic finish_up();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_up();
   end

   initial begin
      rst_n = 0; idle_in(); burst_lin = 1; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      check(rdata_oe === 1'b0, "R1", "drive", 64'(rdata_oe), 0);
      check(rdata === 64'h0, "R1", "data", rdata, 0);
      check(proto_err === 1'b0, "R1", "err", 64'(proto_err), 0);
      rst_n = 1;

      // full sweep: alternate global and all-lane writes, then processor reads
      for (int a = 0; a < DEPTH; a++) wr_c(a, pat(a, 1), a[0] == 0, 8'h00);
      for (int a = 0; a < DEPTH; a++) rd_p(a, a[0] == 1);
      desel("R2");

      // R6 partial lanes
      for (int k = 0; k < 8; k++) begin
         wr_c(48, pat(48 + k, k + 20), 0, ~(8'h01 << k));
         rd_p(48, 0);
      end
      wr_c(49, pat(99, 3), 0, 8'h5A);
      rd_p(49, 0);
      idle_in(); ctrl_stb_n = 0; addr = 49; byte_we_n = 1; lane_we_n = 8'h00; wdata = '1;
      step(1, ref_m[49], "R6");
      idle_in(); ctrl_stb_n = 0; addr = 49; byte_we_n = 0; lane_we_n = 8'hFF; wdata = '1;
      step(1, ref_m[49], "R6");
      rd_p(49, 0);
      desel("R2");

      // R7 bursts in both orders
      burst_lin = 1; rd_p(5, 0);
      for (int k = 1; k < 4; k++) beat_rd(lin(5, k), 1, "R7");
      desel("R2");
      burst_lin = 0; rd_p(6, 0);
      for (int k = 1; k < 4; k++) beat_rd(xo(6, k), 1, "R7");
      desel("R2");
      wr_c(9, pat(9, 40), 1, 8'h00);
      for (int k = 1; k < 4; k++) begin
         idle_in(); adv_n = 0; glob_we_n = 0; wdata = pat(k, 41);
         merge(xo(9, k), wdata, 8'hFF);
         step(0, '0, "R7");
      end
      desel("R2");
      rd_p(9, 0);
      for (int k = 1; k < 4; k++) beat_rd(xo(9, k), 1, "R7");
      desel("R2");
      burst_lin = 1;
      wr_c(14, pat(14, 50), 0, 8'h00);
      for (int k = 1; k < 4; k++) begin
         idle_in(); adv_n = 0; byte_we_n = 0; lane_we_n = 8'h00; wdata = pat(k, 51);
         merge(lin(14, k), wdata, 8'hFF);
         step(0, '0, "R7");
      end
      desel("R2");
      rd_p(14, 0);
      for (int k = 1; k < 4; k++) beat_rd(lin(14, k), 1, "R7");
      desel("R2");

      // R8 processor-started burst with a suspended partial write
      rd_p(16, 1);
      idle_in(); byte_we_n = 0; lane_we_n = 8'h0F; wdata = pat(16, 7);
      merge(16, wdata, 8'hF0);
      step(0, '0, "R8");
      idle_in(); adv_n = 0; glob_we_n = 0; wdata = pat(17, 8);
      merge(17, wdata, 8'hFF);
      step(0, '0, "R7");
      desel("R2");
      rd_p(16, 0); rd_p(17, 0);
      desel("R2");

      // R8 suspended read burst with R10 output-enable gating
      rd_p(24, 0);
      beat_rd(24, 0, "R8");
      beat_rd(25, 1, "R7");
      idle_in(); oe_n = 1; step(1, ref_m[25], "R10");
      beat_rd(26, 1, "R8");
      desel("R2");

      // R3 main enable masks the processor strobe
      rd_p(32, 0);
      idle_in(); proc_stb_n = 0; ce_n = 1; adv_n = 0; addr = 50;
      step(1, ref_m[33], "R3");
      idle_in(); proc_stb_n = 0; ce_n = 1; addr = 51;
      step(1, ref_m[33], "R3");
      desel("R2");

      // R2 / R13 deselect paths
      rd_p(36, 0);
      idle_in(); proc_stb_n = 0; en_hi = 2'b10; step(0, '0, "R2");
      idle_in(); adv_n = 0; step(0, '0, "R13");
      idle_in(); step(0, '0, "R13");
      idle_in(); proc_stb_n = 0; ce_n = 1; step(0, '0, "R13");
      rd_p(37, 0);
      idle_in(); ctrl_stb_n = 0; en_lo_n = 2'b01; step(0, '0, "R2");
      idle_in(); adv_n = 0; step(0, '0, "R13");
      idle_in(); ctrl_stb_n = 0; en_hi = 2'b01; glob_we_n = 0; addr = 38; wdata = '0;
      step(0, '0, "R2");
      rd_p(38, 0);

      // R9 read followed by write
      rd_p(20, 0);
      wr_c(21, pat(21, 60), 1, 8'h00);
      rd_p(21, 0);
      desel("R2");

      // R11 sleep with a read in flight and inputs active
      rd_p(40, 0);
      for (int i = 0; i < 3; i++) begin
         idle_in(); sleep = 1; ctrl_stb_n = 0; glob_we_n = 0; addr = 41; wdata = '0;
         if (i == 0) pend_v = 0;
         step(0, '0, "R11");
      end
      idle_in(); step(0, '0, "R12");
      idle_in(); step(0, '0, "R12");
      check(proto_err === 1'b0, "R12", "err", 64'(proto_err), 0);
      rd_p(41, 0);
      desel("R11");

      // R12 strobe inside the wake window
      idle_in(); sleep = 1; pend_v = 0; step(0, '0, "R11");
      idle_in(); ctrl_stb_n = 0; glob_we_n = 0; addr = 41; wdata = '0;
      step(0, '0, "R12");
      idle_in(); step(0, '0, "R12");
      check(proto_err === 1'b1, "R12", "err", 64'(proto_err), 1);
      rd_p(41, 0);
      desel("R12");
      idle_in(); step(0, '0, "R13");
      idle_in(); step(0, '0, "R13");
      check(proto_err === 1'b1, "R12", "err sticky", 64'(proto_err), 1);
      finish_up();
   end
endmodule